// File: doc/BRIEF.md
# Chunked LFSR Masking Randomness Generator

This block supplies a wide word of pseudo-random bits to a masked cipher datapath. The top slice of the word feeds a key-expansion unit and the rest feeds the masked substitution boxes. The word is built from several independent Galois LFSR chunks. A fixed bit permutation scatters the concatenated chunk state across the output, so neighbouring output bits come from different chunks and taps. The chunks step forward only when the consumer strobes an update, and otherwise the word holds.

Fresh seed material comes from an external entropy source over a request/acknowledge handshake. When a reseed is requested, the generator fetches one entropy word per chunk, lowest chunk first. After the last chunk is written, it returns a one-cycle acknowledge. A build-time option skips the fetch and acknowledges at once. A second option allows a force input to freeze the whole state, so that the output stays constant for side-channel analysis.

Top module: `maskgen_prng`

## Requirements
- R1: After reset, chunk c (bits c*32+31..c*32 of the concatenated state, chunk 0 lowest) holds slice c of the reset-seed parameter. `reseed_ack_o` and `ent_req_o` are low.
- R2: In a cycle with `update_i` high, every chunk advances one Galois step: s' = (s >> 1) XOR (s[0] ? TAPS : 0). With `update_i` low, the state holds.
- R3: Output bit i equals concatenated-state bit (i*PERM_STRIDE) mod 128. The stride is odd and the width a power of two, so this is a bijection.
- R4: `key_rnd_o` is output bits 127..96, and `sbox_rnd_o` is output bits 95..0.
- R5: A high `reseed_req_i` seen while idle raises `ent_req_o` on the next cycle. Each cycle with `ent_req_o` and `ent_ack_i` both high writes the low 32 bits of `ent_data_i` into the next chunk, in ascending order from chunk 0.
- R6: In the cycle after chunk 3 is written, `reseed_ack_o` is high for exactly one cycle and `ent_req_o` is low. The requester holds `reseed_req_i` until it sees the acknowledge.
- R7: A chunk is never zero. An all-zero entropy word or reset seed slice is replaced by the FALLBACK value.
- R8: With forcing allowed and `force_i` high, the output stays constant whatever `update_i` and entropy writes do. The reseed handshake still runs to its acknowledge.
- R9: With the skip-reseed option set, a reseed request is acknowledged in the next cycle and `ent_req_o` never rises.
- R10: In a cycle where a chunk takes entropy while `update_i` is high, that chunk takes the entropy word and the other chunks step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| update_i | input | 1 | Advance all chunks by one step |
| force_i | input | 1 | Freeze state (when allowed by parameter) |
| reseed_req_i | input | 1 | Reseed request, held until acknowledge |
| reseed_ack_o | output | 1 | One-cycle reseed-complete pulse |
| ent_req_o | output | 1 | Entropy word wanted |
| ent_ack_i | input | 1 | Entropy word valid on `ent_data_i` |
| ent_data_i | input | ENT_W | Entropy word |
| rnd_o | output | NUM_CHUNKS*CHUNK_W | Permuted randomness word |
| key_rnd_o | output | KEY_W | Key-expansion slice of `rnd_o` |
| sbox_rnd_o | output | NUM_CHUNKS*CHUNK_W-KEY_W | S-box slice of `rnd_o` |

## Verification
Every chunk is visible through the permutation, so a wrong chunk value or a missed or extra step shows on `rnd_o` one cycle after the offending edge. An entropy word written to the wrong chunk shows as a mismatch in the bits that chunk scatters to, right after that handshake beat. Since each beat is compared on its own, an ordering fault is caught at the first out-of-place word. A control fault shows as a missing, late or doubled `reseed_ack_o` at the cycle after the fourth beat, or as `ent_req_o` rising in skip mode.

// File: rtl/maskgen_pkg.sv
package maskgen_pkg;

  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_FETCH = 2'd1,
    RS_ACK   = 2'd2
  } rs_state_e;

  // Source bit of the concatenated state that drives output bit i.
  function automatic int unsigned perm_src(input int unsigned i,
                                           input int unsigned stride,
                                           input int unsigned width);
    return (i * stride) % width;
  endfunction

endpackage

// File: rtl/maskgen_chunk.sv
module maskgen_chunk #(
  parameter int unsigned W          = 32,
  parameter logic [W-1:0] TAPS       = 32'h8020_0003,
  parameter logic [W-1:0] RESET_SEED = 32'h1,
  parameter logic [W-1:0] FALLBACK   = 32'h1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         freeze_i,
  input  logic         step_i,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] state_o
);

  localparam logic [W-1:0] RESET_VAL = (RESET_SEED == '0) ? FALLBACK : RESET_SEED;

  function automatic logic [W-1:0] galois_next(input logic [W-1:0] s);
    return s[0] ? ((s >> 1) ^ TAPS) : (s >> 1);
  endfunction

  function automatic logic [W-1:0] seed_fix(input logic [W-1:0] s);
    return (s == '0) ? FALLBACK : s;
  endfunction

  logic [W-1:0] state_q;
  logic         do_load;
  logic         do_step;

  assign do_load = load_i & ~freeze_i;
  assign do_step = step_i & ~load_i & ~freeze_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RESET_VAL;
    end else if (do_load) begin
      state_q <= seed_fix(seed_i);
    end else if (do_step) begin
      state_q <= galois_next(state_q);
    end
  end

  assign state_o = state_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(state_o));

  // R8
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(state_o));

  // R7
  nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != '0);

  // R10
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !freeze_i && seed_i != '0) |=> state_o == $past(seed_i));

endmodule

// File: rtl/maskgen_reseed_ctrl.sv
module maskgen_reseed_ctrl
  import maskgen_pkg::*;
#(
  parameter int unsigned N    = 4,
  parameter bit          SKIP = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  output logic         ack_o,
  output logic         ent_req_o,
  input  logic         ent_ack_i,
  output logic [N-1:0] load_o
);

  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  rs_state_e        st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             beat;
  logic             last_beat;

  assign beat      = (st_q == RS_FETCH) && ent_ack_i;
  assign last_beat = beat && (idx_q == LAST);

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    unique case (st_q)
      RS_IDLE: begin
        idx_d = '0;
        if (req_i) st_d = SKIP ? RS_ACK : RS_FETCH;
      end
      RS_FETCH: begin
        if (last_beat)  st_d = RS_ACK;
        else if (beat)  idx_d = idx_q + 1'b1;
      end
      RS_ACK:  st_d = RS_IDLE;
      default: st_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RS_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  for (genvar g = 0; g < N; g++) begin : gen_load
    assign load_o[g] = beat && (idx_q == IDX_W'(g));
  end

  assign ent_req_o = (st_q == RS_FETCH);
  assign ack_o     = (st_q == RS_ACK);

  // R6
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  // R6
  ack_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_beat |=> (ack_o && !ent_req_o));

  // R5
  req_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ent_req_o) |-> $past(req_i));

  if (SKIP) begin : gen_skip_chk
    // R9
    no_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ent_req_o);
  end

endmodule

// File: rtl/maskgen_prng.sv
module maskgen_prng
  import maskgen_pkg::*;
#(
  parameter int unsigned NUM_CHUNKS    = 4,
  parameter int unsigned CHUNK_W       = 32,
  parameter int unsigned ENT_W         = 32,
  parameter int unsigned KEY_W         = 32,
  parameter logic [CHUNK_W-1:0] TAPS    = 32'h8020_0003,
  parameter logic [CHUNK_W-1:0] FALLBACK = 32'h5A5A_0001,
  parameter logic [NUM_CHUNKS*CHUNK_W-1:0] RESET_SEED =
    128'h1357_9BDF_2468_ACE0_0F1E_2D3C_4B5A_6978,
  parameter int unsigned PERM_STRIDE   = 37,
  parameter bit          FORCE_ALLOWED = 1'b1,
  parameter bit          SKIP_RESEED   = 1'b0
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 update_i,
  input  logic                                 force_i,
  input  logic                                 reseed_req_i,
  output logic                                 reseed_ack_o,
  output logic                                 ent_req_o,
  input  logic                                 ent_ack_i,
  input  logic [ENT_W-1:0]                     ent_data_i,
  output logic [NUM_CHUNKS*CHUNK_W-1:0]        rnd_o,
  output logic [KEY_W-1:0]                     key_rnd_o,
  output logic [NUM_CHUNKS*CHUNK_W-KEY_W-1:0]  sbox_rnd_o
);

  localparam int unsigned OUT_W = NUM_CHUNKS * CHUNK_W;
  localparam int unsigned SBOX_W = OUT_W - KEY_W;

  logic [OUT_W-1:0]      state_flat;
  logic [NUM_CHUNKS-1:0] load_vec;
  logic [CHUNK_W-1:0]    seed_word;
  logic                  freeze;

  if (FORCE_ALLOWED) begin : gen_force
    assign freeze = force_i;
  end else begin : gen_no_force
    logic unused_force;
    assign unused_force = force_i;
    assign freeze = 1'b0;
  end

  if (ENT_W == CHUNK_W) begin : gen_ent_eq
    assign seed_word = ent_data_i;
  end else if (ENT_W > CHUNK_W) begin : gen_ent_wide
    assign seed_word = ent_data_i[CHUNK_W-1:0];
  end else begin : gen_ent_narrow
    assign seed_word = {{(CHUNK_W-ENT_W){1'b0}}, ent_data_i};
  end

  maskgen_reseed_ctrl #(
    .N    (NUM_CHUNKS),
    .SKIP (SKIP_RESEED)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (reseed_req_i),
    .ack_o     (reseed_ack_o),
    .ent_req_o (ent_req_o),
    .ent_ack_i (ent_ack_i),
    .load_o    (load_vec)
  );

  for (genvar c = 0; c < NUM_CHUNKS; c++) begin : gen_chunk
    maskgen_chunk #(
      .W          (CHUNK_W),
      .TAPS       (TAPS),
      .RESET_SEED (RESET_SEED[c*CHUNK_W +: CHUNK_W]),
      .FALLBACK   (FALLBACK)
    ) u_chunk (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .freeze_i (freeze),
      .step_i   (update_i),
      .load_i   (load_vec[c]),
      .seed_i   (seed_word),
      .state_o  (state_flat[c*CHUNK_W +: CHUNK_W])
    );
  end

  for (genvar i = 0; i < OUT_W; i++) begin : gen_perm
    assign rnd_o[i] = state_flat[perm_src(i, PERM_STRIDE, OUT_W)];
  end

  assign key_rnd_o  = rnd_o[OUT_W-1 -: KEY_W];
  assign sbox_rnd_o = rnd_o[SBOX_W-1:0];

  // R5
  one_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_vec));

  // R8
  out_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze |=> $stable(rnd_o));

endmodule

// File: tb/test_maskgen_prng.sv
module test_maskgen_prng;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 32;
  localparam int NC = 4;
  localparam int OW = 128;
  localparam int KW = 32;
  localparam logic [31:0]  TAPS = 32'h8020_0003;
  localparam logic [31:0]  FB   = 32'h5A5A_0001;
  localparam logic [127:0] SEED = 128'h1357_9BDF_2468_ACE0_0F1E_2D3C_4B5A_6978;
  localparam logic [127:0] SKIP_SEED = 128'h0123_4567_0000_0000_89AB_CDEF_0BAD_F00D;
  localparam int STRIDE = 37;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic update = 1'b0, force_in = 1'b0, req = 1'b0, eack = 1'b0;
  logic [31:0] edata = '0;
  logic ack, ereq;
  logic [127:0] rnd;
  logic [31:0] krnd;
  logic [95:0] srnd;

  logic req_s = 1'b0;
  logic ack_s, ereq_s;
  logic [127:0] rnd_s;
  logic [31:0] krnd_s;
  logic [95:0] srnd_s;

  int checks = 0;
  int fails = 0;
  logic [3:0][31:0] m;

  always #(CLK_PERIOD/2) clk = ~clk;

  maskgen_prng #(
    .NUM_CHUNKS(NC), .CHUNK_W(CW), .ENT_W(CW), .KEY_W(KW), .TAPS(TAPS),
    .FALLBACK(FB), .RESET_SEED(SEED), .PERM_STRIDE(STRIDE),
    .FORCE_ALLOWED(1'b1), .SKIP_RESEED(1'b0)
  ) i_maskgen_prng (
    .clk_i(clk), .rst_ni(rst_n), .update_i(update), .force_i(force_in),
    .reseed_req_i(req), .reseed_ack_o(ack), .ent_req_o(ereq),
    .ent_ack_i(eack), .ent_data_i(edata), .rnd_o(rnd),
    .key_rnd_o(krnd), .sbox_rnd_o(srnd)
  );

  maskgen_prng #(
    .NUM_CHUNKS(NC), .CHUNK_W(CW), .ENT_W(CW), .KEY_W(KW), .TAPS(TAPS),
    .FALLBACK(FB), .RESET_SEED(SKIP_SEED), .PERM_STRIDE(STRIDE),
    .FORCE_ALLOWED(1'b1), .SKIP_RESEED(1'b1)
  ) i_maskgen_prng_skip (
    .clk_i(clk), .rst_ni(rst_n), .update_i(1'b0), .force_i(1'b0),
    .reseed_req_i(req_s), .reseed_ack_o(ack_s), .ent_req_o(ereq_s),
    .ent_ack_i(1'b0), .ent_data_i(32'h0), .rnd_o(rnd_s),
    .key_rnd_o(krnd_s), .sbox_rnd_o(srnd_s)
  );

  function automatic logic [31:0] step_of(input logic [31:0] s);
    logic [31:0] t;
    t = {1'b0, s[31:1]};
    if (s[0]) t = t ^ TAPS;
    return t;
  endfunction

  function automatic logic [31:0] fix(input logic [31:0] s);
    return (s == 32'h0) ? FB : s;
  endfunction

  function automatic logic [127:0] scramble(input logic [127:0] st);
    logic [127:0] o;
    for (int i = 0; i < OW; i++) o[i] = st[(i * STRIDE) % OW];
    return o;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    for (int c = 0; c < NC; c++) m[c] = step_of(m[c]);
  endtask

  task automatic t_reset();
    m = SEED;
    chk("R1 reset output", rnd, scramble(m));
    chk("R1 reset ack low", {127'h0, ack}, 128'h0);
    chk("R1 reset ent_req low", {127'h0, ereq}, 128'h0);
    chk("R4 key slice", {96'h0, krnd}, {96'h0, scramble(m)[127:96]});
    chk("R4 sbox slice", {32'h0, srnd}, {32'h0, scramble(m)[95:0]});
    // R3: bit 1 comes from state bit 37, bit 4 from state bit 20
    chk("R3 perm bit1", {127'h0, rnd[1]}, {127'h0, m[1][5]});
    chk("R3 perm bit4", {127'h0, rnd[4]}, {127'h0, m[0][20]});
  endtask

  task automatic t_update(input logic [15:0] pattern);
    for (int k = 0; k < 16; k++) begin
      update = pattern[k];
      @(negedge clk);
      if (pattern[k]) model_step();
      chk("R2 update pattern", rnd, scramble(m));
    end
    update = 1'b0;
  endtask

  task automatic t_reseed(input logic [3:0][31:0] w, input logic upd, input logic frz);
    int guard;
    force_in = frz;
    req = 1'b1;
    @(negedge clk);
    guard = 0;
    while (!ereq && guard < 10) begin
      @(negedge clk);
      guard++;
    end
    chk("R5 ent_req raised", {127'h0, ereq}, 128'h1);
    for (int c = 0; c < NC; c++) begin
      eack = 1'b1;
      edata = w[c];
      update = upd;
      @(negedge clk);
      if (!frz) begin
        for (int k = 0; k < NC; k++) begin
          if (k == c) m[k] = fix(w[c]);
          else if (upd) m[k] = step_of(m[k]);
        end
      end
      chk(upd ? "R10 load with update" : "R5 ascending load", rnd, scramble(m));
    end
    eack = 1'b0;
    update = 1'b0;
    chk("R6 ack after last", {127'h0, ack}, 128'h1);
    chk("R6 ent_req dropped", {127'h0, ereq}, 128'h0);
    req = 1'b0;
    @(negedge clk);
    chk("R6 ack single cycle", {127'h0, ack}, 128'h0);
    chk("R6 state after ack", rnd, scramble(m));
    force_in = 1'b0;
  endtask

  task automatic t_force();
    logic [127:0] held;
    held = rnd;
    force_in = 1'b1;
    for (int k = 0; k < 6; k++) begin
      update = 1'b1;
      @(negedge clk);
      chk("R8 forced hold", rnd, held);
    end
    update = 1'b0;
    force_in = 1'b0;
    t_reseed({32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 32'h7777_8888}, 1'b1, 1'b1);
    chk("R8 forced reseed ignored", rnd, held);
    update = 1'b1;
    @(negedge clk);
    update = 1'b0;
    model_step();
    chk("R8 steps after release", rnd, scramble(m));
  endtask

  task automatic t_skip();
    logic [127:0] es;
    logic seen_req;
    es = SKIP_SEED;
    es[95:64] = FB;
    chk("R7 zero reset slice replaced", rnd_s, scramble(es));
    seen_req = 1'b0;
    req_s = 1'b1;
    @(negedge clk);
    seen_req = seen_req | ereq_s;
    chk("R9 skip ack next cycle", {127'h0, ack_s}, 128'h1);
    req_s = 1'b0;
    @(negedge clk);
    seen_req = seen_req | ereq_s;
    chk("R9 skip ack ends", {127'h0, ack_s}, 128'h0);
    chk("R9 no entropy request", {127'h0, seen_req}, 128'h0);
    chk("R9 skip state unchanged", rnd_s, scramble(es));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_update(16'hFFFF);
    t_update(16'h5A3C);
    t_update(16'h0000);
    // R7: chunk 1 gets an all-zero word
    t_reseed({32'hDEAD_BEEF, 32'hC0FF_EE01, 32'h0000_0000, 32'h0102_0304}, 1'b0, 1'b0);
    t_update(16'h00F3);
    t_reseed({32'hA5A5_0F0F, 32'h1234_5678, 32'h8765_4321, 32'hFEDC_BA98}, 1'b1, 1'b0);
    t_force();
    t_skip();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule